// File: doc/BRIEF.md
# Clock Frequency Window Monitor

This block checks two monitored clocks against a trusted RC reference clock. One is a PLL output and the other a crystal oscillator. The reference domain opens measurement windows of a fixed number of reference cycles. Each monitored clock counts its own edges, and at the end of every window the count crosses into the reference domain through a toggle handshake. There it is compared with programmable limits. A PLL count above the high limit or below the low limit raises its own event flag. An oscillator count below the window length, shifted right by a 2-bit divide selector, raises the oscillator-slow flag. That is the same as the oscillator running slower than the RC clock divided by 1, 2, 4 or 8.

A flag can only set when its clock was qualified for the whole window that was measured. For the PLL, this means reported on and locked. For the oscillator, it means reported on and stable. Flags are sticky and are cleared by writing ones to them. A single interrupt line ORs each flag with its own enable bit.

Software reaches the limits, the control word and the flags through a plain register port. A write takes effect in one `ref_clk` cycle and a read is combinational. Neither side can stall, so the port has no valid/ready pair and no back-pressure. The status qualifiers are expected to be synchronous to `ref_clk`.

Top module: `clk_freq_window_mon`

## Requirements
- R1: After reset, the control word reads 0, the high limit reads all ones, the low limit reads 0, all flags read 0, `flags_o` is 0 and `irq` is low.
- R2: Flag bit 0 (high event) sets when the PLL edge count over a window of `WINDOW` reference cycles is greater than the high limit (address 1).
- R3: Flag bit 1 (low event) sets when the PLL edge count over a window is less than the low limit (address 2).
- R4: Flag bit 2 (oscillator slow) sets when the oscillator edge count over a window is less than `WINDOW >> d`, where d is control bits [9:8]. The values 0 to 3 select divides of 1, 2, 4 and 8.
- R5: The PLL flags can set only if `pll_on` and `pll_locked` stayed high for the whole window and are high when its count arrives. The oscillator flag has the same condition on `osc_on` and `osc_stable`. A window that contains even a short drop of the qualifier never sets the flag.
- R6: A flag value of 1 means an event is pending and 0 means none. A set flag stays set after its condition goes away.
- R7: Writing to address 3 clears each flag whose data bit is 1 and leaves the others alone. Bit positions match `flags_o`, and writing 0 has no effect.
- R8: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when some flag and its enable bit are both 1. The enable bits are control bits [2:0], in flag-bit order.
- R10: Reading address 0, 1, 2 or 3 returns the last written control word, the high limit, the low limit, or the flags in bits [2:0] with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Trusted RC reference clock; all registers and flags live here |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_clk | input | 1 | Monitored PLL output clock |
| osc_clk | input | 1 | Monitored crystal oscillator clock |
| pll_on | input | 1 | PLL clock reported running |
| pll_locked | input | 1 | PLL reported locked |
| osc_on | input | 1 | Oscillator reported running |
| osc_stable | input | 1 | Oscillator reported stable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 high limit, 2 low limit, 3 flags) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | CNT_W | Combinational read data |
| flags_o | output | 3 | Event flags: bit 0 high, bit 1 low, bit 2 oscillator slow |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a software clear that lands in the same cycle as a hardware set. The bench cannot see when a window's count arrives. So it keeps a low-frequency condition present and writes a clear to that flag on every reference cycle for several windows. The flag must still be observed high at least once. Qualification is stressed the same way. The lock qualifier is dropped for three cycles on a period shorter than the window, so every window contains a drop. The flag must then never set, even though the clock stays out of range.

// File: rtl/cfwm_pkg.sv
package cfwm_pkg;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLG_HI    = 0;
  localparam int unsigned FLG_LO    = 1;
  localparam int unsigned FLG_OSC   = 2;

  localparam int unsigned NUM_CH    = 2;
  localparam int unsigned CH_PLL    = 0;
  localparam int unsigned CH_OSC    = 1;

  // control word fields
  localparam int unsigned IEN_LSB   = 0;
  localparam int unsigned DIV_LSB   = 8;
  localparam int unsigned DIV_W     = 2;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_HI    = 2'd1,
    ADDR_LO    = 2'd2,
    ADDR_FLAGS = 2'd3
  } cfwm_addr_e;
endpackage

// File: rtl/cfwm_window_timer.sv
module cfwm_window_timer #(
  parameter int unsigned WINDOW = 1024
) (
  input  logic ref_clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned TW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [TW-1:0] LAST = TW'(WINDOW - 1);

  logic [TW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + 1'b1;
  end
endmodule

// File: rtl/cfwm_edge_meter.sv
// Counts edges of one monitored clock and hands the per-window total to
// the reference domain with a toggle request / toggle acknowledge pair.
module cfwm_edge_meter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             mon_clk,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             done
);
  // monitored-domain reset: asynchronous assert, synchronous release
  logic [1:0] mrst_q;
  logic       mrst_n;
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) mrst_q <= 2'b00;
    else        mrst_q <= {mrst_q[0], 1'b1};
  end
  assign mrst_n = mrst_q[1];

  logic             req_t;
  logic             ack_t;
  logic [2:0]       req_s;
  logic [2:0]       ack_s;
  logic [CNT_W-1:0] run;
  logic [CNT_W-1:0] hold;
  logic             busy;
  logic             ack_chg;

  // monitored domain: two sync flops plus a history flop on the request
  always_ff @(posedge mon_clk or negedge mrst_n) begin
    if (!mrst_n) begin
      req_s <= '0;
      ack_t <= 1'b0;
      run   <= '0;
      hold  <= '0;
    end else begin
      req_s <= {req_s[1:0], req_t};
      if (req_s[2] ^ req_s[1]) begin
        hold  <= run;
        run   <= CNT_W'(1);
        ack_t <= ~ack_t;
      end else if (run != '1) begin
        run <= run + 1'b1;
      end
    end
  end

  // reference domain: hold is stable for as long as the acknowledge is in flight
  assign ack_chg = ack_s[2] ^ ack_s[1];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s <= '0;
      req_t <= 1'b0;
      busy  <= 1'b0;
      count <= '0;
      done  <= 1'b0;
    end else begin
      ack_s <= {ack_s[1:0], ack_t};
      done  <= ack_chg;
      if (ack_chg) count <= hold;
      if (tick && (!busy || ack_chg)) begin
        req_t <= ~req_t;
        busy  <= 1'b1;
      end else if (ack_chg) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfwm_regs.sv
module cfwm_regs
  import cfwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 ref_clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic [1:0]           rd_addr,
  output logic [CNT_W-1:0]     rd_data,
  input  logic [NUM_FLAGS-1:0] set_vec,
  output logic [CNT_W-1:0]     hi_ref,
  output logic [CNT_W-1:0]     lo_ref,
  output logic [DIV_W-1:0]     rcdiv,
  output logic [NUM_FLAGS-1:0] irq_en,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  logic [CNT_W-1:0]     ctrl_q;
  logic [NUM_FLAGS-1:0] clr_vec;

  assign rcdiv  = ctrl_q[DIV_LSB +: DIV_W];
  assign irq_en = ctrl_q[IEN_LSB +: NUM_FLAGS];

  assign clr_vec = (wr_en && cfwm_addr_e'(wr_addr) == ADDR_FLAGS)
                   ? wr_data[NUM_FLAGS-1:0] : '0;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      hi_ref <= '1;
      lo_ref <= '0;
    end else if (wr_en) begin
      case (cfwm_addr_e'(wr_addr))
        ADDR_CTRL: ctrl_q <= wr_data;
        ADDR_HI:   hi_ref <= wr_data;
        ADDR_LO:   lo_ref <= wr_data;
        default:   ;
      endcase
    end
  end

  // set wins over a coincident clear
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end

  assign irq = |(flags & irq_en);

  always_comb begin
    case (cfwm_addr_e'(rd_addr))
      ADDR_CTRL: rd_data = ctrl_q;
      ADDR_HI:   rd_data = hi_ref;
      ADDR_LO:   rd_data = lo_ref;
      default:   rd_data = {{(CNT_W-NUM_FLAGS){1'b0}}, flags};
    endcase
  end
endmodule

// File: rtl/clk_freq_window_mon.sv
module clk_freq_window_mon
  import cfwm_pkg::*;
#(
  parameter int unsigned WINDOW = 1024,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                 ref_clk,
  input  logic                 rst_n,
  input  logic                 pll_clk,
  input  logic                 osc_clk,
  input  logic                 pll_on,
  input  logic                 pll_locked,
  input  logic                 osc_on,
  input  logic                 osc_stable,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic [1:0]           rd_addr,
  output logic [CNT_W-1:0]     rd_data,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 irq
);
  localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WINDOW);

  logic                 tick;
  logic [NUM_CH-1:0]    mon_clk;
  logic [NUM_CH-1:0]    qual;
  logic [NUM_CH-1:0]    chan_ok;
  logic [NUM_CH-1:0]    done;
  logic [CNT_W-1:0]     cnt [NUM_CH];
  logic [NUM_FLAGS-1:0] set_vec;
  logic [CNT_W-1:0]     hi_ref;
  logic [CNT_W-1:0]     lo_ref;
  logic [DIV_W-1:0]     rcdiv;
  logic [NUM_FLAGS-1:0] irq_en;
  logic [CNT_W-1:0]     osc_limit;

  assign mon_clk[CH_PLL] = pll_clk;
  assign mon_clk[CH_OSC] = osc_clk;
  assign qual[CH_PLL]    = pll_on & pll_locked;
  assign qual[CH_OSC]    = osc_on & osc_stable;

  cfwm_window_timer #(.WINDOW(WINDOW)) timer_i (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .tick    (tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic ok_run;
    logic ok_win;

    cfwm_edge_meter #(.CNT_W(CNT_W)) meter_i (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .mon_clk (mon_clk[c]),
      .tick    (tick),
      .count   (cnt[c]),
      .done    (done[c])
    );

    // qualifier must hold across a whole window for its count to be trusted
    always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
        ok_run <= 1'b0;
        ok_win <= 1'b0;
      end else if (tick) begin
        ok_win <= ok_run & qual[c];
        ok_run <= 1'b1;
      end else if (!qual[c]) begin
        ok_run <= 1'b0;
      end
    end

    assign chan_ok[c] = ok_win & qual[c];
  end

  assign osc_limit = WIN_C >> rcdiv;

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_HI]  = done[CH_PLL] & chan_ok[CH_PLL] & (cnt[CH_PLL] > hi_ref);
    set_vec[FLG_LO]  = done[CH_PLL] & chan_ok[CH_PLL] & (cnt[CH_PLL] < lo_ref);
    set_vec[FLG_OSC] = done[CH_OSC] & chan_ok[CH_OSC] & (cnt[CH_OSC] < osc_limit);
  end

  cfwm_regs #(.CNT_W(CNT_W)) regs_i (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .set_vec (set_vec),
    .hi_ref  (hi_ref),
    .lo_ref  (lo_ref),
    .rcdiv   (rcdiv),
    .irq_en  (irq_en),
    .flags   (flags_o),
    .irq     (irq)
  );
endmodule

// File: rtl/cfwm_checker.sv
module cfwm_checker #(
  parameter int unsigned NF = 3
) (
  input logic          ref_clk,
  input logic          rst_n,
  input logic          pll_on,
  input logic          pll_locked,
  input logic          osc_on,
  input logic          osc_stable,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [NF-1:0] wr_low,
  input logic [NF-1:0] flags_o,
  input logic          irq,
  input logic [NF-1:0] set_vec,
  input logic [NF-1:0] irq_en
);
  logic [NF-1:0] clr;
  assign clr = (wr_en && wr_addr == 2'd3) ? wr_low : '0;

  assert_pll_set_qualified_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (set_vec[0] || set_vec[1]) |-> (pll_on && pll_locked));

  assert_osc_set_qualified_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    set_vec[2] |-> (osc_on && osc_stable));

  assert_flag_sticky_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (flags_o & ~clr) != '0 |=> ((flags_o & $past(flags_o & ~clr)) == $past(flags_o & ~clr)));

  assert_flag_rises_only_on_set_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(set_vec)) == '0));

  assert_w1c_clears_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (clr & ~set_vec) != '0 |=> ((flags_o & $past(clr & ~set_vec)) == '0));

  assert_set_beats_clear_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    set_vec != '0 |=> ((flags_o & $past(set_vec)) == $past(set_vec)));

  assert_irq_masked_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    irq_en == '0 |-> !irq);

  assert_irq_needs_flag_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    flags_o == '0 |-> !irq);
endmodule

bind clk_freq_window_mon cfwm_checker #(.NF(3)) chk_i (
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .pll_on     (pll_on),
  .pll_locked (pll_locked),
  .osc_on     (osc_on),
  .osc_stable (osc_stable),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_low     (wr_data[2:0]),
  .flags_o    (flags_o),
  .irq        (irq),
  .set_vec    (set_vec),
  .irq_en     (irq_en)
);

// File: tb/clk_freq_window_mon_tb.sv
module clk_freq_window_mon_tb_top;
  localparam int TREF  = 20;
  localparam int WIN   = 128;
  localparam int CW    = 16;
  localparam int HI    = 280;
  localparam int LO    = 200;
  localparam int DOG   = 150000;

  logic          ref_clk = 1'b0;
  logic          pll_clk = 1'b0;
  logic          osc_clk = 1'b0;
  logic          rst_n   = 1'b0;
  logic          pll_on = 1'b1, pll_locked = 1'b1, osc_on = 1'b1, osc_stable = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = 2'd0;
  logic [CW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = 2'd0;
  logic [CW-1:0] rd_data;
  logic [2:0]    flags_o;
  logic          irq;

  int pll_t = 10;
  int osc_t = 12;
  int n_chk = 0;
  int n_fail = 0;
  bit done_run = 1'b0;

  always #(TREF/2) ref_clk = ~ref_clk;
  always #(pll_t/2) pll_clk = ~pll_clk;
  always #(osc_t/2) osc_clk = ~osc_clk;

  clk_freq_window_mon #(.WINDOW(WIN), .CNT_W(CW)) dut_i (
    .ref_clk(ref_clk), .rst_n(rst_n), .pll_clk(pll_clk), .osc_clk(osc_clk),
    .pll_on(pll_on), .pll_locked(pll_locked), .osc_on(osc_on), .osc_stable(osc_stable),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .flags_o(flags_o), .irq(irq)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge ref_clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[CW-1:0];
    @(negedge ref_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = a[1:0];
    #1;
    v = int'(rd_data);
  endtask

  task automatic measure();
    cyc(2*WIN);
    wr(3, 7);
    cyc(3*WIN + 40);
  endtask

  function automatic int exp_flags(input int pt, input int ot, input int d);
    int pc = WIN*TREF/pt;
    int oc = WIN*TREF/ot;
    return ((pc > HI) ? 1 : 0) | ((pc < LO) ? 2 : 0) | ((oc < (WIN >> d)) ? 4 : 0);
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (DOG) @(posedge ref_clk);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  initial begin
    int v;
    int pts[3];
    int ots[3];
    bit seen;
    pts = '{10, 8, 16};
    ots = '{28, 60, 100};

    cyc(3);
    rst_n = 1'b1;
    @(negedge ref_clk);
    // R1 reset values
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 hi", v, 16'hFFFF);
    rd(2, v); chk("R1 lo", v, 0);
    rd(3, v); chk("R1 flags", v, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 flags_o", int'(flags_o), 0);

    // R10 readback
    wr(1, HI); wr(2, LO); wr(0, 16'h0300);
    rd(0, v); chk("R10 ctrl", v, 16'h0300);
    rd(1, v); chk("R10 hi", v, HI);
    rd(2, v); chk("R10 lo", v, LO);
    wr(0, 0);

    // R2 R3 PLL window sweep
    foreach (pts[i]) begin
      pll_t = pts[i];
      measure();
      chk($sformatf("R2/R3 pll period %0d", pll_t), int'(flags_o), exp_flags(pll_t, osc_t, 0));
    end

    // R4 oscillator sweep over all divide selections
    pll_t = 10;
    foreach (ots[i]) begin
      for (int d = 0; d < 4; d++) begin
        osc_t = ots[i];
        wr(0, d << 8);
        measure();
        chk($sformatf("R4 osc period %0d div %0d", osc_t, d), int'(flags_o), exp_flags(pll_t, osc_t, d));
      end
    end

    // R5 qualification
    wr(0, 0);
    osc_t = 12;
    pll_t = 16;
    pll_locked = 1'b0;
    measure();
    chk("R5 unlocked", int'(flags_o), 0);
    pll_locked = 1'b1; pll_on = 1'b0;
    measure();
    chk("R5 pll off", int'(flags_o), 0);
    pll_on = 1'b1;
    fork
      measure();
      begin
        repeat (8) begin
          cyc(100);
          pll_locked = 1'b0;
          cyc(3);
          pll_locked = 1'b1;
        end
      end
    join
    chk("R5 lock glitch every window", int'(flags_o), 0);
    measure();
    chk("R5 lock steady", int'(flags_o), 2);
    pll_t = 10; osc_t = 100; osc_stable = 1'b0;
    measure();
    chk("R5 osc unstable", int'(flags_o), 0);
    osc_stable = 1'b1;
    measure();
    chk("R5 osc stable", int'(flags_o), 4);
    osc_t = 12;

    // R6 sticky, R7 write-one-to-clear
    pll_t = 16;
    measure();
    chk("R3 low event", int'(flags_o), 2);
    pll_t = 10;
    cyc(3*WIN);
    chk("R6 sticky after condition gone", int'(flags_o), 2);
    wr(3, 0);
    chk("R7 write zero", int'(flags_o), 2);
    wr(3, 1);
    chk("R7 other bit cleared only", int'(flags_o), 2);

    // R9 interrupt masking
    wr(0, 1);
    chk("R9 other enable", int'(irq), 0);
    wr(0, 2);
    chk("R9 matching enable", int'(irq), 1);
    wr(0, 7);
    chk("R9 all enables", int'(irq), 1);
    wr(3, 2);
    chk("R7 clear bit 1", int'(flags_o), 0);
    chk("R9 irq after clear", int'(irq), 0);
    wr(0, 0);

    // R8 set wins over a coincident clear
    pll_t = 16;
    cyc(2*WIN);
    seen = 1'b0;
    @(negedge ref_clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0002;
    for (int k = 0; k < 3*WIN; k++) begin
      @(negedge ref_clk);
      if (flags_o[1]) seen = 1'b1;
    end
    wr_en = 1'b0;
    chk("R8 flag seen under constant clear", int'(seen), 1);

    done_run = 1'b1;
    report();
  end
endmodule